// File: doc/BRIEF.md
# Planar Frame Buffer Write Datapath

This block forms the bytes written into a frame buffer built from four parallel memory planes, each one byte wide. On each processor write strobe it combines the processor byte, a set of configuration inputs and four read latches into one byte per plane. It also produces a per-plane write enable. The configuration inputs are a write mode, a rotate count, a per-plane constant colour, a per-plane substitute enable, a per-bit mask and a per-plane mask. Both outputs are registered, so they reflect a write strobe on the clock edge after it is sampled.

The read latches keep the byte most recently read from each plane. They are loaded from the plane-read bus whenever the read strobe is high. Some modes merge their new data with these latched bytes, bit by bit, under a mask, so a read-modify-write of a whole pixel group needs only one processor write.

The memory itself, address decoding, display refresh and the host bus protocol belong to other blocks.

Top module: `pfb_write_path`

## Requirements
- R1: While `rst` is high at a clock edge, `wr_en` and `wr_data` become all zeros and every read latch is cleared.
- R2: Mode 0 (`wr_mode`=00), plane p with `sr_en[p]`=0: bit b of its byte is the rotated processor byte where `bit_mask[b]`=1 and latch p bit b where `bit_mask[b]`=0. The rotated byte is `cpu_data` rotated right by `rot_cnt`, so rotated bit b = `cpu_data[(b+rot_cnt) mod 8]`.
- R3: Mode 0, plane p with `sr_en[p]`=1: the rotated byte is replaced by `sr_val[p]` copied into all 8 bits, and is then merged with latch p under `bit_mask` in the same way as R2.
- R4: Mode 1 (`wr_mode`=01): every plane's byte equals its read latch, whatever `cpu_data`, `bit_mask`, `rot_cnt`, `sr_val` and `sr_en` are.
- R5: Mode 2 (`wr_mode`=10): `cpu_data[p]` is copied into every bit of plane p where `bit_mask` is 1, and latch p supplies the bits where `bit_mask` is 0. There is no rotation.
- R6: Mode 3 (`wr_mode`=11): the effective mask is the rotated processor byte ANDed with `bit_mask`. Where the effective mask is 1, plane p takes `sr_val[p]`; where it is 0, plane p takes its latch. `sr_en` has no effect.
- R7: When `rd_stb` is high at an edge, all four latches load their bytes from `rd_data` (plane p in bits 8p+7..8p). A write sampled at that same edge uses the latch contents from before the load.
- R8: The edge after a sampled `wr_stb`, `wr_en` equals the `plane_mask` sampled with it and `wr_data` holds the new plane bytes (plane p in bits 8p+7..8p).
- R9: The edge after a cycle without `wr_stb`, `wr_en` is zero and `wr_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 2 | Write mode select |
| rot_cnt | input | 3 | Right-rotate amount for processor data |
| sr_val | input | 4 | Per-plane constant colour bit |
| sr_en | input | 4 | Per-plane substitute enable for mode 0 |
| bit_mask | input | 8 | Per-bit select: 1 new data, 0 latch |
| plane_mask | input | 4 | Per-plane write permission |
| cpu_data | input | 8 | Processor write byte |
| wr_stb | input | 1 | Processor write strobe |
| rd_stb | input | 1 | Processor read strobe, loads latches |
| rd_data | input | 32 | Bytes read from the four planes |
| wr_data | output | 32 | Registered plane write bytes |
| wr_en | output | 4 | Registered per-plane write enables |

## Verification
The assertions assume that the strobes and configuration are stable around the clock edge. They also assume that a value presented with a strobe is the value meant for that edge, because they compare outputs against `$past` of those inputs. The bench drives every input on the falling edge, pulses each strobe for exactly one cycle and samples on the next falling edge, so each assertion sees one clean strobe. The sweeps cover every rotate count with every substitute-enable pattern, and every processor byte in mode 2. A same-edge read and write is exercised on purpose, to fix the latch ordering.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    WM_REPLACE = 2'd0,
    WM_LATCH   = 2'd1,
    WM_COLOR   = 2'd2,
    WM_SRMASK  = 2'd3
  } wmode_e;
endpackage

// File: rtl/pfb_rotate.sv
module pfb_rotate #(
  parameter int W  = 8,
  parameter int RW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [RW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] dbl;
  always_comb begin
    dbl  = {din, din} >> amt;
    dout = dbl[W-1:0];
  end
endmodule

// File: rtl/pfb_latches.sv
module pfb_latches #(
  parameter int W = 8,
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [P*W-1:0] din,
  output logic [P*W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  a_r7_latch_load: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/pfb_plane_lane.sv
module pfb_plane_lane
  import pfb_pkg::*;
#(
  parameter int W = 8
) (
  input  wmode_e       mode,
  input  logic [W-1:0] rot_data,
  input  logic         color_bit,
  input  logic         sr_bit,
  input  logic         sr_on,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] latch,
  output logic [W-1:0] dout
);
  logic [W-1:0] src;
  logic [W-1:0] sel;

  always_comb begin
    src = rot_data;
    sel = mask;
    unique case (mode)
      WM_REPLACE: src = sr_on ? {W{sr_bit}} : rot_data;
      WM_LATCH: begin
        src = latch;
        sel = '0;
      end
      WM_COLOR:  src = {W{color_bit}};
      WM_SRMASK: begin
        src = {W{sr_bit}};
        sel = rot_data & mask;
      end
      default: src = rot_data;
    endcase
    dout = (src & sel) | (latch & ~sel);
  end

  always_comb begin
    if (mode == WM_LATCH)
      a_r4_lane_copy: assert (dout == latch);
  end
endmodule

// File: rtl/pfb_write_path.sv
module pfb_write_path
  import pfb_pkg::*;
#(
  parameter int W  = 8,
  parameter int P  = 4,
  localparam int RW = $clog2(W),
  localparam int DW = P * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    wr_mode,
  input  logic [RW-1:0] rot_cnt,
  input  logic [P-1:0]  sr_val,
  input  logic [P-1:0]  sr_en,
  input  logic [W-1:0]  bit_mask,
  input  logic [P-1:0]  plane_mask,
  input  logic [W-1:0]  cpu_data,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] wr_data,
  output logic [P-1:0]  wr_en
);
  logic [W-1:0]  rot_data;
  logic [DW-1:0] latch_q;
  logic [DW-1:0] lane_out;
  wmode_e        mode;

  assign mode = wmode_e'(wr_mode);

  pfb_rotate #(.W(W)) u_rot (
    .din  (cpu_data),
    .amt  (rot_cnt),
    .dout (rot_data)
  );

  pfb_latches #(.W(W), .P(P)) u_lat (
    .clk  (clk),
    .rst  (rst),
    .load (rd_stb),
    .din  (rd_data),
    .q    (latch_q)
  );

  for (genvar p = 0; p < P; p++) begin : g_lane
    pfb_plane_lane #(.W(W)) u_lane (
      .mode      (mode),
      .rot_data  (rot_data),
      .color_bit (cpu_data[p % W]),
      .sr_bit    (sr_val[p]),
      .sr_on     (sr_en[p]),
      .mask      (bit_mask),
      .latch     (latch_q[p*W +: W]),
      .dout      (lane_out[p*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data <= '0;
      wr_en   <= '0;
    end else begin
      wr_en <= wr_stb ? plane_mask : '0;
      if (wr_stb) wr_data <= lane_out;
    end
  end

  a_r8_enable_follows_mask: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> wr_en == $past(plane_mask));
  a_r9_idle_no_enable: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> wr_en == '0);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(wr_data));
  a_r4_latch_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_mode == 2'd1) |=> wr_data == $past(latch_q));
endmodule

// File: tb/test_pfb_write_path.sv
module test_pfb_write_path;
  localparam int W = 8;
  localparam int P = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    wr_mode;
  logic [2:0]    rot_cnt;
  logic [P-1:0]  sr_val, sr_en, plane_mask;
  logic [W-1:0]  bit_mask, cpu_data;
  logic          wr_stb, rd_stb;
  logic [P*W-1:0] rd_data, wr_data;
  logic [P-1:0]  wr_en;

  int checks = 0;
  int errors = 0;
  logic [P*W-1:0] lat_m;
  logic [P*W-1:0] last_out;

  always #5 clk = ~clk;

  pfb_write_path i_pfb_write_path (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .rot_cnt(rot_cnt),
    .sr_val(sr_val), .sr_en(sr_en), .bit_mask(bit_mask),
    .plane_mask(plane_mask), .cpu_data(cpu_data), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .rd_data(rd_data), .wr_data(wr_data), .wr_en(wr_en)
  );

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [P*W-1:0] model(input logic [1:0] m, input logic [2:0] r,
      input logic [P-1:0] sv, input logic [P-1:0] se, input logic [W-1:0] bm,
      input logic [W-1:0] cd, input logic [P*W-1:0] lat);
    logic [P*W-1:0] res;
    for (int p = 0; p < P; p++) begin
      for (int b = 0; b < W; b++) begin
        logic rb, lb, nb, sl;
        rb = cd[(b + r) % W];
        lb = lat[p*W + b];
        nb = lb;
        case (m)
          2'd0: begin sl = bm[b]; nb = se[p] ? sv[p] : rb; end
          2'd1: begin sl = 1'b0; end
          2'd2: begin sl = bm[b]; nb = cd[p]; end
          default: begin sl = rb & bm[b]; nb = sv[p]; end
        endcase
        res[p*W + b] = sl ? nb : lb;
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [P*W-1:0] act,
      input logic [P*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [P*W-1:0] d);
    @(negedge clk);
    rd_stb = 1'b1; rd_data = d;
    @(negedge clk);
    rd_stb = 1'b0;
    lat_m = d;
  endtask

  task automatic do_write(input string req, input logic [1:0] m, input logic [2:0] r,
      input logic [P-1:0] sv, input logic [P-1:0] se, input logic [W-1:0] bm,
      input logic [W-1:0] cd, input logic [P-1:0] pm);
    logic [P*W-1:0] exp;
    @(negedge clk);
    wr_mode = m; rot_cnt = r; sr_val = sv; sr_en = se; bit_mask = bm;
    cpu_data = cd; plane_mask = pm; wr_stb = 1'b1;
    exp = model(m, r, sv, se, bm, cd, lat_m);
    @(negedge clk);
    wr_stb = 1'b0;
    check(req, wr_data, exp);
    check("R8", {28'd0, wr_en}, {28'd0, pm});
    last_out = exp;
  endtask

  initial begin
    rst = 1'b1; wr_mode = 0; rot_cnt = 0; sr_val = 0; sr_en = 0; bit_mask = 0;
    plane_mask = 0; cpu_data = 0; wr_stb = 0; rd_stb = 0; rd_data = 0;
    lat_m = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", wr_data, '0);
    check("R1", {28'd0, wr_en}, '0);
    rst = 1'b0;
    // R1 latches cleared: mode 1 write returns zeros
    do_write("R1", 2'd1, 3'd0, 4'hF, 4'hF, 8'hFF, 8'hA5, 4'hF);

    // R2 / R3 sweep: every rotate count with every substitute pattern
    for (int r = 0; r < 8; r++) begin
      for (int se = 0; se < 16; se++) begin
        do_read({$urandom, $urandom} & 32'hFFFF_FFFF);
        do_write(se == 0 ? "R2" : "R3", 2'd0, 3'(r), 4'($urandom), 4'(se),
                 8'($urandom), 8'($urandom), 4'($urandom));
      end
    end
    // R2 full mask: pure rotation
    do_read(32'h0);
    do_write("R2", 2'd0, 3'd3, 4'h0, 4'h0, 8'hFF, 8'h81, 4'hF);

    // R4 latch copy ignores other inputs
    for (int i = 0; i < 32; i++) begin
      do_read($urandom);
      do_write("R4", 2'd1, 3'($urandom), 4'($urandom), 4'($urandom),
               8'($urandom), 8'($urandom), 4'($urandom));
    end

    // R5 every processor byte
    for (int c = 0; c < 256; c++) begin
      do_read($urandom);
      do_write("R5", 2'd2, 3'($urandom), 4'($urandom), 4'($urandom),
               8'($urandom), 8'(c), 4'hF);
    end

    // R6 every rotate count, random data, sr_en must not matter
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 16; i++) begin
        do_read($urandom);
        do_write("R6", 2'd3, 3'(r), 4'($urandom), 4'(i),
                 8'($urandom), 8'($urandom), 4'($urandom));
      end
    end

    // R7 same-edge read and write: write uses old latches
    do_read(32'h1234_5678);
    @(negedge clk);
    wr_mode = 2'd1; wr_stb = 1'b1; plane_mask = 4'hF;
    rd_stb = 1'b1; rd_data = 32'hCAFE_F00D;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
    check("R7", wr_data, 32'h1234_5678);
    lat_m = 32'hCAFE_F00D;
    do_write("R7", 2'd1, 3'd0, 4'h0, 4'h0, 8'h00, 8'h00, 4'h5);

    // R9 idle cycles: no enable, data held
    @(negedge clk);
    cpu_data = 8'h3C; wr_mode = 2'd0; bit_mask = 8'hFF; plane_mask = 4'hF;
    @(negedge clk);
    check("R9", wr_data, last_out);
    check("R9", {28'd0, wr_en}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule